// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Read Bypass

This block is a single-clock synchronous memory with a one-stage read pipeline and a late-write scheme. On every rising edge it registers the address, an active-low select, an active-low write command and one active-low write enable per 9-bit byte lane. Read data is loaded into an output register at the following edge.

Write data trails its command by one cycle. It is held, together with its address and lane mask, in a posted-write buffer. The buffer is retired into the array only when the next write command delivers its own data, and any number of reads may come in between. A read whose address matches the buffered address takes the lanes that buffered write enabled from the buffer and the remaining lanes from the array, so software always sees the newest data.

An output enable and a sleep input both force the data outputs undriven. The sleep input also blocks commands, both while it is high and for a fixed number of recovery cycles after it falls. Stored contents are kept across sleep.

Top module: `lw_sram`

## Requirements
- R1: A read command registered at edge k loads the output register at edge k+1. The read data is driven only after edge k+1 and not in the cycle between edge k and edge k+1.
- R2: The data of a write is taken from `d_in` at the edge after the one that registered the write command. The value on `d_in` in the command cycle is not stored.
- R3: A write is held in a posted buffer and retired to the array when the next write's data is captured. A read of the buffered address returns the new data both before and after retirement.
- R4: Lane i covers bits [9i+8:9i], and lane i is written when bit i of `lane_wr_n` is 0. A read that hits a partially written buffer returns the enabled lanes from the buffer and the other lanes from the array, both before and after retirement.
- R5: A write with `lane_wr_n` all ones changes no stored data.
- R6: When `sel_n` is high the command is a no-operation: nothing is written and the outputs are undriven in the following cycle.
- R7: While `oe_n` is high, `q_drive` is 0 regardless of the command. Reads and writes proceed, and `q_out` keeps the value of the last read.
- R8: During the data cycle of a write, `q_drive` is 0 even when the previous command was a read.
- R9: While `sleep` is high, `q_drive` is 0 at once and every command is ignored. Stored data, including the posted buffer, is preserved.
- R10: After `sleep` falls, commands sampled at the next WAKE_CYC edges are ignored. The command at the following edge is accepted.
- R11: Back-to-back reads of one address with no write in between keep `q_out` unchanged.
- R12: After reset, `q_drive` is 0, `q_out` is all zeros and the posted buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write command (high means read) |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| d_in | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Power-down request, active high |
| q_out | output | LANES*LANE_W | Output register contents |
| q_drive | output | 1 | High when `q_out` is driven onto the bus; low means Hi-Z |

## Verification
Reads are tried against three sources:
- a word already retired to the array, which checks the array path;
- the word still in the posted buffer, which separates bypass from array access;
- a word whose buffer holds only some lanes, which separates per-lane merging from whole-word bypass.

Write data is offered with a decoy value in the command cycle, which tells the one-cycle-late capture apart from a same-cycle capture. Sleep and recovery are exercised with writes and reads placed inside and just after the blocked window, so that an off-by-one recovery count shows up as a changed word or a driven bus.

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      sel_n,
  input  logic                      wr_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [LANES*LANE_W-1:0]   d_in,
  input  logic                      oe_n,
  input  logic                      sleep,
  output logic [LANES*LANE_W-1:0]   q_out,
  output logic                      q_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WAKE_CYC + 2);

  logic [CNT_W-1:0]  wake_cnt;
  logic              awake;
  logic              c1_rd, c1_wr;
  logic [ADDR_W-1:0] a1;
  logic [LANES-1:0]  m1;
  logic              buf_valid;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_mask;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arr_word, rd_word, q_reg;
  logic              out_valid, hit;

  assign awake = !sleep && (wake_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                wake_cnt <= '0;
    else if (sleep)            wake_cnt <= CNT_W'(WAKE_CYC);
    else if (wake_cnt != '0)   wake_cnt <= wake_cnt - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c1_rd <= 1'b0;
      c1_wr <= 1'b0;
      a1    <= '0;
      m1    <= '0;
    end else begin
      c1_rd <= awake && !sel_n && wr_n;
      c1_wr <= awake && !sel_n && !wr_n;
      a1    <= addr;
      m1    <= ~lane_wr_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_mask  <= '0;
      buf_data  <= '0;
    end else if (c1_wr) begin
      buf_valid <= 1'b1;
      buf_addr  <= a1;
      buf_mask  <= m1;
      buf_data  <= d_in;
    end

  always_ff @(posedge clk)
    if (c1_wr && buf_valid)
      for (int l = 0; l < LANES; l++)
        if (buf_mask[l]) mem[buf_addr][l*LANE_W +: LANE_W] <= buf_data[l*LANE_W +: LANE_W];

  assign arr_word = mem[a1];
  assign hit      = buf_valid && (buf_addr == a1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (hit && buf_mask[g]) ? buf_data[g*LANE_W +: LANE_W]
                                                              : arr_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_reg     <= '0;
    end else begin
      out_valid <= c1_rd;
      if (c1_rd) q_reg <= rd_word;
    end

  assign q_out   = q_reg;
  assign q_drive = out_valid && !c1_wr && !oe_n && !sleep;

  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!c1_rd && !c1_wr));

  assert_recovery_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != '0) |=> (!c1_rd && !c1_wr));

  assert_same_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_rd && $past(c1_rd) && (a1 == $past(a1))) |=> $stable(q_reg));

  assert_buffer_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |=> buf_valid);

  assert_nonread_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !c1_rd |=> !q_drive);
endmodule

// File: tb/test_lw_sram.sv
`timescale 1ns/1ps
module test_lw_sram;
  localparam int AW = 6, LN = 4, LW = 9, WAKE = 3;
  localparam int DW = LN * LW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1, wr_n = 1, oe_n = 0, sleep = 0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic q_drive;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [1<<AW];

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .WAKE_CYC(WAKE)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
    .q_out(q_out), .q_drive(q_drive));

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] ln_n);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < LN; l++) if (!ln_n[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic step(input logic s_n, input logic w_n, input logic [AW-1:0] a,
                      input logic [LN-1:0] ln, input logic [DW-1:0] d);
    @(posedge clk); #1;
    sel_n = s_n; wr_n = w_n; addr = a; lane_wr_n = ln; d_in = d;
  endtask

  task automatic nop(input logic [DW-1:0] d = '0);
    step(1'b1, 1'b1, '0, '1, d);
  endtask

  task automatic chk(input logic exp_drv, input logic [DW-1:0] exp_q, input bit cmp_q, input string req);
    #1;
    n_cmp++;
    if (q_drive !== exp_drv || (cmp_q && q_out !== exp_q)) begin
      n_bad++;
      $display("FAIL %s: drive=%b q=%h expected drive=%b q=%h", req, q_drive, q_out, exp_drv, exp_q);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] ln, input logic [DW-1:0] d);
    step(1'b0, 1'b0, a, ln, ~d);
    nop(d);
    ref_mem[a] = merge(ref_mem[a], d, ln);
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string req);
    step(1'b0, 1'b1, a, '1, '0);
    nop();
    nop();
    chk(1'b1, ref_mem[a], 1'b1, req);
  endtask

  task automatic t_reset;
    chk(1'b0, '0, 1'b1, "R12 reset outputs");
    nop();
    chk(1'b0, '0, 1'b1, "R12 idle after reset");
  endtask

  task automatic t_basic;
    wr(6'd5, 4'b0000, 36'h1A5A5A5A5);
    wr(6'd6, 4'b0000, 36'h0C3C3C3C3);
    step(1'b0, 1'b1, 6'd5, '1, '0);
    nop();
    chk(1'b0, '0, 1'b0, "R1 not yet driven");
    nop();
    chk(1'b1, 36'h1A5A5A5A5, 1'b1, "R1 read latency / R2 late data");
    rd_check(6'd6, "R3 bypass of buffered word");
  endtask

  task automatic t_posted;
    wr(6'd10, 4'b0000, 36'h123456789);
    rd_check(6'd10, "R3 read buffered");
    rd_check(6'd10, "R3 read buffered again");
    wr(6'd11, 4'b0000, 36'h0FEDCBA98);
    rd_check(6'd10, "R3 read after retirement");
    rd_check(6'd11, "R3 read new buffer");
  endtask

  task automatic t_lanes;
    wr(6'd20, 4'b0000, 36'hAAAAAAAAA);
    wr(6'd21, 4'b0000, 36'h555555555);
    wr(6'd20, 4'b1010, 36'h0F0F0F0F0);
    rd_check(6'd20, "R4 merged bypass");
    wr(6'd22, 4'b0000, 36'h000000111);
    rd_check(6'd20, "R4 merged after retirement");
    rd_check(6'd21, "R4 neighbour word");
  endtask

  task automatic t_no_lanes;
    wr(6'd20, 4'b1111, 36'h999999999);
    rd_check(6'd20, "R5 empty-mask write buffered");
    wr(6'd23, 4'b0000, 36'h222222222);
    rd_check(6'd20, "R5 empty-mask write retired");
  endtask

  task automatic t_deselect;
    step(1'b1, 1'b0, 6'd20, 4'b0000, 36'h777777777);
    nop(36'h777777777);
    chk(1'b0, '0, 1'b0, "R6 deselected undriven");
    wr(6'd24, 4'b0000, 36'h333333333);
    rd_check(6'd20, "R6 deselected write stored nothing");
  endtask

  task automatic t_oe;
    rd_check(6'd20, "R7 baseline read");
    oe_n = 1;
    chk(1'b0, '0, 1'b0, "R7 oe high undriven");
    oe_n = 0;
    chk(1'b1, ref_mem[20], 1'b1, "R7 value kept");
    oe_n = 1;
    wr(6'd25, 4'b0000, 36'h444444444);
    step(1'b0, 1'b1, 6'd25, '1, '0);
    nop();
    nop();
    chk(1'b0, '0, 1'b0, "R7 read with oe high undriven");
    oe_n = 0;
    chk(1'b1, 36'h444444444, 1'b1, "R7 read with oe high completed");
  endtask

  task automatic t_write_turn;
    step(1'b0, 1'b1, 6'd20, '1, '0);
    step(1'b0, 1'b0, 6'd26, 4'b0000, ~36'h666666666);
    nop(36'h666666666);
    ref_mem[26] = 36'h666666666;
    chk(1'b0, '0, 1'b0, "R8 write data cycle undriven");
    rd_check(6'd26, "R8 write after read stored");
  endtask

  task automatic t_repeat;
    step(1'b0, 1'b1, 6'd20, '1, '0);
    step(1'b0, 1'b1, 6'd20, '1, '0);
    step(1'b0, 1'b1, 6'd20, '1, '0);
    chk(1'b1, ref_mem[20], 1'b1, "R11 first of repeated reads");
    nop();
    chk(1'b1, ref_mem[20], 1'b1, "R11 second of repeated reads");
    nop();
    chk(1'b1, ref_mem[20], 1'b1, "R11 third of repeated reads");
    nop();
  endtask

  task automatic t_sleep;
    wr(6'd30, 4'b0000, 36'h030303030);
    wr(6'd31, 4'b0000, 36'h031313131);
    step(1'b0, 1'b1, 6'd30, '1, '0);
    nop();
    nop();
    sleep = 1;
    chk(1'b0, '0, 1'b0, "R9 sleep undriven at once");
    step(1'b0, 1'b0, 6'd30, 4'b0000, '0);
    nop(36'hDEADBEEF0);
    step(1'b0, 1'b0, 6'd31, 4'b0000, '0);
    nop(36'hDEADBEEF1);
    chk(1'b0, '0, 1'b0, "R9 asleep undriven");
    nop();
    sleep = 0;
    for (int i = 0; i < WAKE + 1; i++) nop();
    rd_check(6'd30, "R9 array word preserved");
    rd_check(6'd31, "R9 buffered word preserved");
  endtask

  task automatic t_recovery;
    sleep = 1;
    nop();
    nop();
    nop();
    sleep = 0;
    step(1'b0, 1'b0, 6'd30, 4'b0000, '0);
    step(1'b0, 1'b1, 6'd30, '1, 36'h0BADBAD00);
    nop();
    nop();
    chk(1'b0, '0, 1'b0, "R10 read in recovery ignored");
    rd_check(6'd30, "R10 write in recovery ignored");
    sleep = 1;
    nop();
    sleep = 0;
    for (int i = 0; i < WAKE - 1; i++) nop();
    step(1'b0, 1'b0, 6'd32, 4'b0000, '0);
    nop(36'h032323232);
    ref_mem[32] = 36'h032323232;
    rd_check(6'd32, "R10 first command after recovery accepted");
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_posted();
    t_lanes();
    t_no_lanes();
    t_deselect();
    t_oe();
    t_write_turn();
    t_repeat();
    t_sleep();
    t_recovery();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule